// File: doc/BRIEF.md
# Global-History Two-Level Direction Predictor

This block predicts whether a conditional branch at the fetch address will be taken. A shift register holds the outcomes of the most recent resolved branches, and its value chooses one of several banks of 2-bit saturating counters. A few bits of the fetch PC, taken just above the two zero alignment bits, pick the counter within that bank. The counter's upper bit is the prediction. Because the bank is chosen by the recent outcomes of other branches, a branch whose direction follows its neighbours' directions trains a separate counter for each recent-outcome pattern.

Lookup is combinational: the fetch front end presents a PC and reads the prediction in the same cycle. It also captures `hist_o` at that moment and returns it later on the resolve port together with the branch PC and the real outcome. On a resolve, the counter addressed by that returned history and PC is trained, and the outcome is shifted into the history register. Restoring history after a misprediction and target prediction are handled elsewhere.

Top module: `bp_two_level`

## Requirements
- R1: While `rst_ni` is low and after its release, `hist_o` is zero and every counter holds 2'b01 (weakly not-taken), so every lookup predicts not-taken.
- R2: On each clock edge with `res_valid_i` high, `hist_o` becomes `{hist_o[HIST_W-2:0], res_taken_i}`: the newest outcome enters bit 0 (1 = taken) and the oldest is dropped.
- R3: On a clock edge with `res_valid_i` low, `hist_o` and all counters keep their values, whatever the other resolve inputs carry.
- R4: `pred_taken_o` is bit 1 of the counter at index `{hist_o, lookup_pc_i[IDX_W+1:2]}`, with the history in the upper index bits.
- R5: A taken resolve raises the addressed counter by one and stops at 3. A not-taken resolve lowers it by one and stops at 0. From 3, one not-taken outcome still predicts taken.
- R6: A resolve trains the counter at `{res_hist_i, res_pc_i[IDX_W+1:2]}`. It uses the returned history, not the current `hist_o`, and leaves all other counters unchanged.
- R7: PC bits [1:0] and bits above IDX_W+1 have no effect on lookup or training.
- R8: A lookup in the same cycle as a resolve to the same counter shows the counter's old value. The new value is visible after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_pc_i | input | PC_W | Fetch PC to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| hist_o | output | HIST_W | Current global outcome history |
| res_valid_i | input | 1 | Resolve strobe |
| res_pc_i | input | PC_W | PC of the resolved branch |
| res_hist_i | input | HIST_W | History captured when that branch was predicted |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench keeps its own array of 64 counters and its own history. After every resolve it sweeps all 16 PC indices at the current history, so a mix-up between the history and PC fields of the index shows up as a wrong bank. One entry is driven past both saturation limits to separate saturating counters from wrapping ones. A long walk trains with returned histories that differ from `hist_o`, which shows whether the update uses the returned value or the live one. Noisy upper and low PC bits test aliasing, idle cycles with active-looking resolve fields test that nothing changes, and a same-entry lookup taken during an update checks the old-value read.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q, hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = taken_i;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_W-2:0], taken_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int unsigned HIST_W = 2,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned ADDR_W  = HIST_W + IDX_W,
  localparam int unsigned ENTRIES = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] upd_idx_i,
  input  logic              upd_taken_i,
  output ctr_t              tbl_o [ENTRIES]
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    ctr_t ctr_q;
    logic hit;
    assign hit = upd_en_i && (upd_idx_i == ADDR_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ctr_q <= CTR_WEAK_NT;
      else if (hit) ctr_q <= ctr_next(ctr_q, upd_taken_i);
    end

    assign tbl_o[e] = ctr_q;
  end
endmodule

// File: rtl/bp_two_level.sv
module bp_two_level
  import bp_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned HIST_W = 2,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned ADDR_W  = HIST_W + IDX_W,
  localparam int unsigned ENTRIES = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic              pred_taken_o,
  output logic [HIST_W-1:0] hist_o,
  input  logic              res_valid_i,
  input  logic [PC_W-1:0]   res_pc_i,
  input  logic [HIST_W-1:0] res_hist_i,
  input  logic              res_taken_i
);
  logic [HIST_W-1:0] hist;
  logic [ADDR_W-1:0] look_idx, upd_idx;
  ctr_t              tbl [ENTRIES];

  // bits outside the index field are intentionally dropped
  logic unused_pc_bits;
  assign unused_pc_bits = ^{lookup_pc_i[PC_W-1:IDX_W+2], lookup_pc_i[1:0],
                            res_pc_i[PC_W-1:IDX_W+2], res_pc_i[1:0]};

  assign look_idx = {hist,       lookup_pc_i[IDX_W+1:2]};
  assign upd_idx  = {res_hist_i, res_pc_i[IDX_W+1:2]};

  bp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (res_valid_i),
    .taken_i (res_taken_i),
    .hist_o  (hist)
  );

  bp_pht #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_pht (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_en_i    (res_valid_i),
    .upd_idx_i   (upd_idx),
    .upd_taken_i (res_taken_i),
    .tbl_o       (tbl)
  );

  assign pred_taken_o = tbl[look_idx][1];
  assign hist_o       = hist;
endmodule

// File: rtl/bp_two_level_chk.sv
module bp_two_level_chk
  import bp_pkg::*;
#(
  parameter int unsigned HIST_W = 2,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned ADDR_W  = HIST_W + IDX_W,
  localparam int unsigned ENTRIES = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              res_valid_i,
  input logic              res_taken_i,
  input logic [HIST_W-1:0] hist_i,
  input logic [ADDR_W-1:0] upd_idx_i,
  input ctr_t              tbl_i [ENTRIES]
);
  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) hist_reset_chk: assert (hist_i == '0);
  end

  // R2
  hist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> hist_i[0] == $past(res_taken_i));

  // R3
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(hist_i));

  // R5
  ctr_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_taken_i) |=>
      (tbl_i[$past(upd_idx_i)] == (($past(tbl_i[upd_idx_i]) == 2'b11) ? 2'b11
                                   : 2'($past(tbl_i[upd_idx_i]) + 2'd1))));

  // R5
  ctr_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_taken_i) |=>
      (tbl_i[$past(upd_idx_i)] == (($past(tbl_i[upd_idx_i]) == 2'b00) ? 2'b00
                                   : 2'($past(tbl_i[upd_idx_i]) - 2'd1))));
endmodule

bind bp_two_level bp_two_level_chk #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .res_valid_i (res_valid_i),
  .res_taken_i (res_taken_i),
  .hist_i      (hist_o),
  .upd_idx_i   (upd_idx),
  .tbl_i       (tbl)
);

// File: tb/tb_bp_two_level.sv
module tb_bp_two_level;
  localparam int PC_W = 32, HIST_W = 2, IDX_W = 4;
  localparam int NIDX = 1 << IDX_W, NENT = 1 << (HIST_W + IDX_W);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PC_W-1:0] lookup_pc = '0, res_pc = '0;
  logic [HIST_W-1:0] res_hist = '0, hist;
  logic res_valid = 1'b0, res_taken = 1'b0, pred;

  int errors = 0, checks = 0;
  int model [NENT];
  int mhist = 0;

  always #10 clk = ~clk;

  bp_two_level #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lookup_pc), .pred_taken_o(pred),
    .hist_o(hist), .res_valid_i(res_valid), .res_pc_i(res_pc),
    .res_hist_i(res_hist), .res_taken_i(res_taken)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] mk_pc(int idx, int salt);
    logic [PC_W-1:0] p;
    p = PC_W'(salt) * 32'h9E37_79B1;
    p[IDX_W+1:2] = IDX_W'(idx);
    return p;
  endfunction

  task automatic look_all(string req, int salt);
    for (int p = 0; p < NIDX; p++) begin
      lookup_pc = mk_pc(p, salt + p);
      #1;
      chk(req, int'(pred), (model[mhist * NIDX + p] >> 1) & 1);
    end
  endtask

  task automatic resolve(int idx, int h, int t, int salt, string req);
    int e;
    @(negedge clk);
    res_valid = 1'b1; res_pc = mk_pc(idx, salt);
    res_hist = HIST_W'(h); res_taken = t[0];
    @(posedge clk);
    e = h * NIDX + idx;
    if (t[0]) model[e] = (model[e] == 3) ? 3 : model[e] + 1;
    else      model[e] = (model[e] == 0) ? 0 : model[e] - 1;
    mhist = ((mhist << 1) | (t & 1)) & (NENT / NIDX - 1);
    @(negedge clk);
    res_valid = 1'b0;
    chk(req, int'(hist), mhist);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NENT; i++) model[i] = 1;
    // R1: state during reset and after release
    #5;
    chk("R1", int'(hist), 0);
    look_all("R1", 3);
    @(negedge clk); rst_n = 1'b1;
    #1; chk("R1", int'(hist), 0);
    look_all("R1", 11);

    // R5: saturate entry {3,9} upward, then one not-taken keeps taken
    for (int i = 0; i < 5; i++) resolve(9, 3, 1, i, "R2");
    look_all("R5", 20);
    chk("R5", model[3 * NIDX + 9], 3);
    resolve(9, 3, 0, 7, "R2");
    resolve(0, 2, 1, 8, "R2");
    resolve(0, 1, 1, 9, "R2");
    look_all("R5", 30);
    // drive {3,9} to floor and beyond
    for (int i = 0; i < 5; i++) resolve(9, 3, 0, 40 + i, "R2");
    resolve(1, 0, 1, 50, "R2");
    resolve(1, 1, 1, 51, "R2");
    look_all("R5", 60);

    // R6: train with returned history unrelated to the live one
    for (int i = 0; i < 96; i++) begin
      resolve((i * 7) % NIDX, (i / 3) % 4, ((i * 5 + 1) % 3) != 0 ? 1 : 0,
              100 + i, "R2");
      look_all("R6", 200 + i);
    end

    // R7: heavy PC noise outside the index field
    for (int i = 0; i < 24; i++) begin
      resolve(i % NIDX, mhist, i % 4 != 0 ? 1 : 0, 77777 * i + 3, "R7");
      look_all("R7", 5000 + 13 * i);
    end

    // R4: alternate outcomes so every bank is looked at
    for (int i = 0; i < 16; i++) begin
      resolve(i, 3 - (i % 4), i % 2, 900 + i, "R2");
      look_all("R4", 1000 + i);
    end

    // R3: idle cycles with busy-looking resolve fields
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      res_valid = 1'b0; res_taken = 1'b1; res_hist = HIST_W'(i);
      res_pc = mk_pc(i, i);
      @(negedge clk);
      chk("R3", int'(hist), mhist);
      look_all("R3", 3000 + i);
    end

    // R8: lookup of the entry being updated shows the old value
    for (int i = 0; i < 6; i++) begin
      int idx, e;
      idx = 4 + i;
      e = mhist * NIDX + idx;
      @(negedge clk);
      lookup_pc = mk_pc(idx, 7);
      res_valid = 1'b1; res_pc = mk_pc(idx, 9); res_hist = HIST_W'(mhist);
      res_taken = (model[e] < 2) ? 1'b1 : 1'b0;
      #1;
      chk("R8", int'(pred), (model[e] >> 1) & 1);
      @(posedge clk);
      if (res_taken) model[e] = (model[e] == 3) ? 3 : model[e] + 1;
      else           model[e] = (model[e] == 0) ? 0 : model[e] - 1;
      mhist = ((mhist << 1) | int'(res_taken)) & 3;
      @(negedge clk);
      res_valid = 1'b0;
      chk("R2", int'(hist), mhist);
      look_all("R8", 4000 + i);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule